// File: doc/BRIEF.md
# DRAM Auto-Refresh Command Sequencer

This block lives inside a DDR SDRAM controller. It owns the command bus for the duration of one refresh episode. When the controller raises a request while the sequencer is idle, the block captures several inputs at that moment:

- which banks currently hold an open row;
- the precharge and refresh recovery times, in clock cycles;
- how many refresh commands to issue;
- whether a row should be reopened afterwards, and which one.

It then runs the episode on its own. If any row is open, it closes the rows with a precharge and waits out the precharge time. It then issues one or more AUTO REFRESH commands, each followed by a recovery window in which only NOP is driven. If asked, it finally issues an ACTIVE command that reopens a chosen row.

While the episode runs, a busy flag tells the rest of the controller to keep off the bus. A single-cycle done pulse marks the end. Clock enable is held high throughout, and the data output enable is held low. When idle, the block drives COMMAND INHIBIT, so that its pins can be merged with other command sources.

Top module: `ref_seq_top`

## Requirements
- R1: A request seen while `busy_o` is low is accepted at that clock edge. The first command appears in the next cycle. It is PRECHARGE when any bit of `open_banks_i` is set, otherwise AUTO REFRESH, and in the no-bank case no precharge and no precharge wait occur.
- R2: With two or more banks open, the PRECHARGE drives address bit 10 high, the rest of the address low and `ba_o` = 0. With exactly one bank open, address bit 10 and the rest of the address are low, and `ba_o` carries that bank's index.
- R3: The first AUTO REFRESH follows the PRECHARGE by exactly max(`trp_i`,1) cycles, with NOP in between.
- R4: After every AUTO REFRESH, the next command or the done cycle comes exactly max(`trfc_i`,1) cycles later. Every cycle in between drives NOP.
- R5: Exactly `num_refs_i`+1 AUTO REFRESH commands are issued back to back (1 to 8 with the default width). Each one has its own full recovery window.
- R6: When `reopen_i` was set at acceptance, an ACTIVE command carrying `reopen_row_i` on the address bus and `reopen_bank_i` on `ba_o` is issued in the cycle the last recovery window expires.
- R7: `done_o` is a one-cycle pulse. It comes in the cycle the last recovery window expires, or in the cycle after the ACTIVE when a row is reopened. `busy_o` is high from the cycle after acceptance through the done cycle, and low after it.
- R8: `cke_o` is high and `dq_oe_o` is low in every cycle.
- R9: Commands are encoded as follows, with pins listed as {CS#,RAS#,CAS#,WE#}:

  | Command | Pins |
  |---|---|
  | inhibit | 1111 |
  | NOP | 0111 |
  | PRECHARGE | 0010 |
  | AUTO REFRESH | 0001 |
  | ACTIVE | 0011 |

  The idle block drives inhibit. Address and bank outputs are zero except during PRECHARGE and ACTIVE.
- R10: Inputs are captured only at acceptance. Requests and changes to any input while busy do not alter the sequence in progress.
- R11: During and right after reset, the block is idle: inhibit on the bus, `busy_o` and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Refresh request, accepted when idle |
| open_banks_i | input | NUM_BANKS | One bit per bank holding an open row |
| trp_i | input | CNT_W | Precharge time in cycles |
| trfc_i | input | CNT_W | Refresh recovery time in cycles |
| num_refs_i | input | RC_W | Number of refreshes minus one |
| reopen_i | input | 1 | Issue ACTIVE after the last refresh |
| reopen_row_i | input | ROW_W | Row address for the ACTIVE |
| reopen_bank_i | input | BA_W | Bank address for the ACTIVE |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address bus |
| ba_o | output | BA_W | Bank address bus |
| cke_o | output | 1 | Clock enable |
| dq_oe_o | output | 1 | Data bus output enable |
| busy_o | output | 1 | Sequencer owns the command bus |
| done_o | output | 1 | One-cycle end-of-episode pulse |

## Verification
The bench builds the block with its defaults:

- four banks, which gives a two-bit bank address;
- a 13-bit address with the auto-precharge bit at position 10;
- 8-bit timing counts;
- up to eight refreshes.

Four banks make the all-bank, single-bank and no-bank precharge cases reachable, including single banks at every index. The 8-bit counts allow timing values of 0, 1 and 2, where the wait state is skipped or shortest, alongside longer random windows. The three-bit refresh count reaches the full run of eight back-to-back refreshes.

// File: rtl/ref_seq_pkg.sv
package ref_seq_pkg;

   typedef enum logic [2:0] {
      CMD_INHIBIT,
      CMD_NOP,
      CMD_PRE,
      CMD_REF,
      CMD_ACT
   } cmd_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PRE,
      S_TRP,
      S_REF,
      S_RFC,
      S_ACT,
      S_DONE
   } state_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } pins_t;

endpackage

// File: rtl/ref_cmd_encode.sv
module ref_cmd_encode
   import ref_seq_pkg::*;
(
   input  cmd_e  cmd_i,
   output pins_t pins_o
);

   always_comb begin
      case (cmd_i)
         CMD_NOP: pins_o = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
         CMD_PRE: pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
         CMD_REF: pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
         CMD_ACT: pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
         default: pins_o = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      endcase
   end

endmodule

// File: rtl/ref_gap_timer.sv
module ref_gap_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   input  logic             dec_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (dec_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ref_bank_scan.sv
module ref_bank_scan #(
   parameter int NUM_BANKS = 4,
   localparam int BA_W = $clog2(NUM_BANKS),
   localparam int PC_W = $clog2(NUM_BANKS + 1)
) (
   input  logic [NUM_BANKS-1:0] banks_i,
   output logic                 multi_o,
   output logic [BA_W-1:0]      idx_o
);

   logic [PC_W-1:0] pop;

   always_comb begin
      pop = '0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         pop = pop + PC_W'(banks_i[i]);
      end
   end

   always_comb begin
      idx_o = '0;
      for (int i = NUM_BANKS - 1; i >= 0; i--) begin
         if (banks_i[i]) idx_o = BA_W'(i);
      end
   end

   assign multi_o = (pop > PC_W'(1));

endmodule

// File: rtl/ref_seq_top.sv
module ref_seq_top
   import ref_seq_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 13,
   parameter int ROW_W     = 13,
   parameter int AP_BIT    = 10,
   parameter int CNT_W     = 8,
   parameter int MAX_REFS  = 8,
   localparam int BA_W     = $clog2(NUM_BANKS),
   localparam int RC_W     = $clog2(MAX_REFS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_i,
   input  logic [NUM_BANKS-1:0] open_banks_i,
   input  logic [CNT_W-1:0]     trp_i,
   input  logic [CNT_W-1:0]     trfc_i,
   input  logic [RC_W-1:0]      num_refs_i,
   input  logic                 reopen_i,
   input  logic [ROW_W-1:0]     reopen_row_i,
   input  logic [BA_W-1:0]      reopen_bank_i,
   output logic                 cs_n_o,
   output logic                 ras_n_o,
   output logic                 cas_n_o,
   output logic                 we_n_o,
   output logic [ADDR_W-1:0]    addr_o,
   output logic [BA_W-1:0]      ba_o,
   output logic                 cke_o,
   output logic                 dq_oe_o,
   output logic                 busy_o,
   output logic                 done_o
);

   // elaboration-time parameter checks
   if (NUM_BANKS < 2 || (1 << BA_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must lie inside the address bus");
   end
   if (ROW_W > ADDR_W || ROW_W < 1) begin : g_bad_row
      $error("ROW_W must be between 1 and ADDR_W");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (MAX_REFS < 2 || (1 << RC_W) != MAX_REFS) begin : g_bad_refs
      $error("MAX_REFS must be a power of two, at least 2");
   end

   localparam logic [ADDR_W-1:0] ALL_BANKS_ADDR = ADDR_W'(1) << AP_BIT;

   state_e               state_q, state_d;
   logic [NUM_BANKS-1:0] banks_q;
   logic [CNT_W-1:0]     trp_q, trfc_q;
   logic [RC_W-1:0]      ref_left_q;
   logic                 more_q;
   logic                 reopen_q;
   logic [ROW_W-1:0]     row_q;
   logic [BA_W-1:0]      bank_q;

   logic                 accept;
   logic                 tmr_load, tmr_dec, tmr_zero;
   logic [CNT_W-1:0]     tmr_val;
   logic                 multi;
   logic [BA_W-1:0]      one_idx;
   logic [ADDR_W-1:0]    act_addr;
   cmd_e                 cmd;
   pins_t                pins;
   state_e               after_ref, after_rfc;
   logic                 more_now;

   assign accept = (state_q == S_IDLE) && req_i;

   // capture of request parameters at acceptance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         banks_q  <= '0;
         trp_q    <= '0;
         trfc_q   <= '0;
         reopen_q <= 1'b0;
         row_q    <= '0;
         bank_q   <= '0;
      end else if (accept) begin
         banks_q  <= open_banks_i;
         trp_q    <= trp_i;
         trfc_q   <= trfc_i;
         reopen_q <= reopen_i;
         row_q    <= reopen_row_i;
         bank_q   <= reopen_bank_i;
      end
   end

   // remaining refresh count
   assign more_now = (ref_left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_left_q <= '0;
         more_q     <= 1'b0;
      end else if (accept) begin
         ref_left_q <= num_refs_i;
         more_q     <= 1'b0;
      end else if (state_q == S_REF) begin
         more_q <= more_now;
         if (more_now) ref_left_q <= ref_left_q - 1'b1;
      end
   end

   assign after_ref = more_now ? S_REF : (reopen_q ? S_ACT : S_DONE);
   assign after_rfc = more_q   ? S_REF : (reopen_q ? S_ACT : S_DONE);

   // next-state logic
   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      tmr_dec  = 1'b0;
      case (state_q)
         S_IDLE: begin
            if (req_i) state_d = (|open_banks_i) ? S_PRE : S_REF;
         end
         S_PRE: begin
            if (trp_q <= CNT_W'(1)) begin
               state_d = S_REF;
            end else begin
               state_d  = S_TRP;
               tmr_load = 1'b1;
               tmr_val  = trp_q - CNT_W'(2);
            end
         end
         S_TRP: begin
            tmr_dec = 1'b1;
            if (tmr_zero) state_d = S_REF;
         end
         S_REF: begin
            if (trfc_q <= CNT_W'(1)) begin
               state_d = after_ref;
            end else begin
               state_d  = S_RFC;
               tmr_load = 1'b1;
               tmr_val  = trfc_q - CNT_W'(2);
            end
         end
         S_RFC: begin
            tmr_dec = 1'b1;
            if (tmr_zero) state_d = after_rfc;
         end
         S_ACT:   state_d = S_DONE;
         S_DONE:  state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= S_IDLE;
      else        state_q <= state_d;
   end

   ref_gap_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .dec_i  (tmr_dec),
      .zero_o (tmr_zero)
   );

   ref_bank_scan #(
      .NUM_BANKS (NUM_BANKS)
   ) u_scan (
      .banks_i (banks_q),
      .multi_o (multi),
      .idx_o   (one_idx)
   );

   // row placement on the address bus
   if (ROW_W == ADDR_W) begin : g_row_full
      assign act_addr = row_q;
   end else begin : g_row_pad
      assign act_addr = {{(ADDR_W - ROW_W){1'b0}}, row_q};
   end

   // command selection
   always_comb begin
      case (state_q)
         S_IDLE:  cmd = CMD_INHIBIT;
         S_PRE:   cmd = CMD_PRE;
         S_REF:   cmd = CMD_REF;
         S_ACT:   cmd = CMD_ACT;
         default: cmd = CMD_NOP;
      endcase
   end

   ref_cmd_encode u_enc (
      .cmd_i  (cmd),
      .pins_o (pins)
   );

   always_comb begin
      addr_o = '0;
      ba_o   = '0;
      if (state_q == S_PRE) begin
         addr_o = multi ? ALL_BANKS_ADDR : '0;
         ba_o   = multi ? '0 : one_idx;
      end else if (state_q == S_ACT) begin
         addr_o = act_addr;
         ba_o   = bank_q;
      end
   end

   assign cs_n_o  = pins.cs_n;
   assign ras_n_o = pins.ras_n;
   assign cas_n_o = pins.cas_n;
   assign we_n_o  = pins.we_n;
   assign cke_o   = 1'b1;
   assign dq_oe_o = 1'b0;
   assign busy_o  = (state_q != S_IDLE);
   assign done_o  = (state_q == S_DONE);

endmodule

// File: rtl/ref_seq_chk.sv
module ref_seq_chk #(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 13,
   parameter int ROW_W     = 13,
   parameter int AP_BIT    = 10,
   parameter int CNT_W     = 8,
   parameter int MAX_REFS  = 8,
   localparam int BA_W     = $clog2(NUM_BANKS),
   localparam int RC_W     = $clog2(MAX_REFS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_i,
   input logic [NUM_BANKS-1:0] open_banks_i,
   input logic [CNT_W-1:0]     trp_i,
   input logic [CNT_W-1:0]     trfc_i,
   input logic [RC_W-1:0]      num_refs_i,
   input logic                 reopen_i,
   input logic [ROW_W-1:0]     reopen_row_i,
   input logic [BA_W-1:0]      reopen_bank_i,
   input logic                 cs_n_o,
   input logic                 ras_n_o,
   input logic                 cas_n_o,
   input logic                 we_n_o,
   input logic [ADDR_W-1:0]    addr_o,
   input logic [BA_W-1:0]      ba_o,
   input logic                 busy_o,
   input logic                 done_o
);

   localparam int GW = CNT_W + 1;

   logic             accept, is_pre, is_ref, is_act, is_quiet;
   logic [CNT_W-1:0] trp_l, trfc_l;
   logic [GW-1:0]    eff_trp, eff_trfc, since_pre, since_ref;
   logic             pre_seen, ref_seen, multi_l, reopen_l;
   logic [RC_W-1:0]  nref_l;
   logic [RC_W:0]    refs_q;
   logic [ROW_W-1:0] row_l;
   logic [BA_W-1:0]  bank_l;

   assign accept   = req_i && !busy_o;
   assign is_pre   = !cs_n_o && !ras_n_o &&  cas_n_o && !we_n_o;
   assign is_ref   = !cs_n_o && !ras_n_o && !cas_n_o &&  we_n_o;
   assign is_act   = !cs_n_o && !ras_n_o &&  cas_n_o &&  we_n_o;
   assign is_quiet = cs_n_o || (ras_n_o && cas_n_o && we_n_o);
   assign eff_trp  = (trp_l  <= CNT_W'(1)) ? GW'(1) : GW'(trp_l);
   assign eff_trfc = (trfc_l <= CNT_W'(1)) ? GW'(1) : GW'(trfc_l);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trp_l     <= '0;
         trfc_l    <= '0;
         multi_l   <= 1'b0;
         reopen_l  <= 1'b0;
         nref_l    <= '0;
         row_l     <= '0;
         bank_l    <= '0;
         pre_seen  <= 1'b0;
         ref_seen  <= 1'b0;
         since_pre <= '0;
         since_ref <= '0;
         refs_q    <= '0;
      end else begin
         if (accept) begin
            trp_l    <= trp_i;
            trfc_l   <= trfc_i;
            multi_l  <= ($countones(open_banks_i) > 1);
            reopen_l <= reopen_i;
            nref_l   <= num_refs_i;
            row_l    <= reopen_row_i;
            bank_l   <= reopen_bank_i;
            pre_seen <= 1'b0;
            ref_seen <= 1'b0;
            refs_q   <= '0;
         end else begin
            if (is_pre) pre_seen <= 1'b1;
            if (is_ref) begin
               ref_seen <= 1'b1;
               refs_q   <= refs_q + 1'b1;
            end
         end
         if (is_pre) since_pre <= GW'(1);
         else if (since_pre != '1) since_pre <= since_pre + 1'b1;
         if (is_ref) since_ref <= GW'(1);
         else if (since_ref != '1) since_ref <= since_ref + 1'b1;
      end
   end

   AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_seen && since_pre < eff_trp) |-> !is_ref) else $error("pre gap"); // R3

   AST_RFC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_seen && since_ref < eff_trfc) |-> is_quiet) else $error("rfc quiet"); // R4

   AST_REF_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (refs_q == (RC_W+1)'(nref_l) + (RC_W+1)'(1))) else $error("ref count"); // R5

   AST_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pre && multi_l) |-> addr_o[AP_BIT]) else $error("all banks"); // R2

   AST_ACT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> (reopen_l && addr_o[ROW_W-1:0] == row_l && ba_o == bank_l)) else $error("act row"); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o) else $error("done pulse"); // R7

   AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(done_o)) else $error("busy end"); // R7

   AST_IDLE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cs_n_o && ras_n_o && cas_n_o && we_n_o)) else $error("idle inhibit"); // R9

   AST_BUSY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !cs_n_o) else $error("busy select"); // R9

endmodule

bind ref_seq_top ref_seq_chk #(
   .NUM_BANKS (NUM_BANKS),
   .ADDR_W    (ADDR_W),
   .ROW_W     (ROW_W),
   .AP_BIT    (AP_BIT),
   .CNT_W     (CNT_W),
   .MAX_REFS  (MAX_REFS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_i         (req_i),
   .open_banks_i  (open_banks_i),
   .trp_i         (trp_i),
   .trfc_i        (trfc_i),
   .num_refs_i    (num_refs_i),
   .reopen_i      (reopen_i),
   .reopen_row_i  (reopen_row_i),
   .reopen_bank_i (reopen_bank_i),
   .cs_n_o        (cs_n_o),
   .ras_n_o       (ras_n_o),
   .cas_n_o       (cas_n_o),
   .we_n_o        (we_n_o),
   .addr_o        (addr_o),
   .ba_o          (ba_o),
   .busy_o        (busy_o),
   .done_o        (done_o)
);

// File: tb/tb_ref_seq_top.sv
module tb_ref_seq_top;

   localparam int NB = 4;
   localparam int AW = 13;
   localparam int RW = 13;
   localparam int CW = 8;
   localparam int BW = 2;
   localparam int QW = 3;
   localparam int MAXE = 512;

   localparam logic [2:0] K_INH = 3'd0, K_NOP = 3'd1, K_PRE = 3'd2,
                          K_REF = 3'd3, K_ACT = 3'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0;
   logic [NB-1:0] open_banks_i = '0;
   logic [CW-1:0] trp_i = '0, trfc_i = '0;
   logic [QW-1:0] num_refs_i = '0;
   logic          reopen_i = 1'b0;
   logic [RW-1:0] reopen_row_i = '0;
   logic [BW-1:0] reopen_bank_i = '0;
   logic          cs_n_o, ras_n_o, cas_n_o, we_n_o;
   logic [AW-1:0] addr_o;
   logic [BW-1:0] ba_o;
   logic          cke_o, dq_oe_o, busy_o, done_o;

   int n_chk = 0;
   int n_bad = 0;

   logic [2:0]    e_cmd  [MAXE];
   logic [AW-1:0] e_addr [MAXE];
   logic [BW-1:0] e_ba   [MAXE];
   logic          e_done [MAXE];
   logic          e_busy [MAXE];
   string         e_tag  [MAXE];
   int            n_e;

   always #4 clk = ~clk;

   ref_seq_top dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .open_banks_i(open_banks_i),
      .trp_i(trp_i), .trfc_i(trfc_i), .num_refs_i(num_refs_i),
      .reopen_i(reopen_i), .reopen_row_i(reopen_row_i), .reopen_bank_i(reopen_bank_i),
      .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
      .addr_o(addr_o), .ba_o(ba_o), .cke_o(cke_o), .dq_oe_o(dq_oe_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   function automatic logic [3:0] pins_of(input logic [2:0] k);
      case (k)
         K_NOP:   return 4'b0111;
         K_PRE:   return 4'b0010;
         K_REF:   return 4'b0001;
         K_ACT:   return 4'b0011;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic int eff(input logic [CW-1:0] t);
      return (t <= 1) ? 1 : int'(t);
   endfunction

   task automatic check(input logic ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [2:0] k, input logic [AW-1:0] a,
                       input logic [BW-1:0] b, input logic d, input logic bz,
                       input string tag);
      e_cmd[n_e] = k; e_addr[n_e] = a; e_ba[n_e] = b;
      e_done[n_e] = d; e_busy[n_e] = bz; e_tag[n_e] = tag;
      n_e++;
   endtask

   task automatic run_seq(input logic [NB-1:0] banks, input logic [CW-1:0] trp,
                          input logic [CW-1:0] trfc, input logic [QW-1:0] nm1,
                          input logic reop, input logic [RW-1:0] row,
                          input logic [BW-1:0] bk, input logic scr);
      logic          multi;
      logic [BW-1:0] idx;
      logic [20:0]   act_v, exp_v;
      multi = ($countones(banks) > 1);
      idx = '0;
      for (int i = NB - 1; i >= 0; i--) if (banks[i]) idx = BW'(i);
      n_e = 0;
      // R1, R2, R3: precharge and its wait only when a bank is open
      if (banks != '0) begin
         push(K_PRE, multi ? 13'h0400 : 13'h0, multi ? 2'd0 : idx, 1'b0, 1'b1, "R2");
         for (int i = 1; i < eff(trp); i++) push(K_NOP, '0, '0, 1'b0, 1'b1, "R3");
      end
      // R4, R5: nm1+1 refreshes, each with its own window
      for (int r = 0; r <= int'(nm1); r++) begin
         push(K_REF, '0, '0, 1'b0, 1'b1, "R5");
         for (int i = 1; i < eff(trfc); i++) push(K_NOP, '0, '0, 1'b0, 1'b1, "R4");
      end
      if (reop) push(K_ACT, row, bk, 1'b0, 1'b1, "R6");
      push(K_NOP, '0, '0, 1'b1, 1'b1, "R7");
      push(K_INH, '0, '0, 1'b0, 1'b0, "R9");
      e_tag[0] = {"R1/", e_tag[0]};

      @(negedge clk);
      open_banks_i = banks; trp_i = trp; trfc_i = trfc; num_refs_i = nm1;
      reopen_i = reop; reopen_row_i = row; reopen_bank_i = bk; req_i = 1'b1;
      @(posedge clk);
      for (int i = 0; i < n_e; i++) begin
         @(negedge clk);
         act_v = {cs_n_o, ras_n_o, cas_n_o, we_n_o, addr_o, ba_o, done_o, busy_o};
         exp_v = {pins_of(e_cmd[i]), e_addr[i], e_ba[i], e_done[i], e_busy[i]};
         check(act_v == exp_v, scr ? {"R10/", e_tag[i]} : e_tag[i], 64'(act_v), 64'(exp_v));
         check(cke_o && !dq_oe_o, "R8", {62'd0, cke_o, dq_oe_o}, 64'd2);
         if (scr && i < n_e - 1) begin
            // R10: garbage on every input while busy
            req_i = 1'($urandom); open_banks_i = NB'($urandom);
            trp_i = CW'($urandom); trfc_i = CW'($urandom);
            num_refs_i = QW'($urandom); reopen_i = 1'($urandom);
            reopen_row_i = RW'($urandom); reopen_bank_i = BW'($urandom);
         end else begin
            req_i = 1'b0;
         end
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: in reset
      check({cs_n_o, ras_n_o, cas_n_o, we_n_o, busy_o, done_o} == 6'b111100, "R11",
            {58'd0, cs_n_o, ras_n_o, cas_n_o, we_n_o, busy_o, done_o}, 64'h3c);
      rst_n = 1'b1;
      @(negedge clk);
      check({cs_n_o, ras_n_o, cas_n_o, we_n_o, busy_o, done_o} == 6'b111100, "R11",
            {58'd0, cs_n_o, ras_n_o, cas_n_o, we_n_o, busy_o, done_o}, 64'h3c);

      // directed corners
      run_seq(4'b0000, 8'd5, 8'd6, 3'd0, 1'b0, 13'h0, 2'd0, 1'b0); // R1 no bank
      run_seq(4'b0100, 8'd3, 8'd4, 3'd0, 1'b0, 13'h0, 2'd0, 1'b0); // R2 single bank 2
      run_seq(4'b1000, 8'd2, 8'd2, 3'd0, 1'b1, 13'h1abc, 2'd1, 1'b0); // R2 bank 3, R6
      run_seq(4'b1011, 8'd0, 8'd1, 3'd1, 1'b0, 13'h0, 2'd0, 1'b0); // R3 tRP=0
      run_seq(4'b0110, 8'd1, 8'd0, 3'd7, 1'b1, 13'h0f0f, 2'd2, 1'b0); // R5 eight refreshes
      run_seq(4'b1111, 8'd9, 8'd12, 3'd7, 1'b1, 13'h1fff, 2'd3, 1'b1); // R10
      run_seq(4'b0000, 8'd0, 8'd2, 3'd2, 1'b1, 13'h0001, 2'd0, 1'b1); // R10

      // constrained random
      for (int s = 0; s < 40; s++) begin
         run_seq(NB'($urandom), CW'($urandom % 12), CW'($urandom % 16),
                 QW'($urandom), 1'($urandom), RW'($urandom), BW'($urandom),
                 1'($urandom));
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule